// File: doc/BRIEF.md
# Scanline Interrupt Burst Scheduler

This block raises a short train of interrupt requests at a chosen position on the screen, as a light-gun style input source needs. Software hands it a line number, an extra horizontal offset counted in cycles, and a repeat count. The block measures time on its own cycle clock. It works out how far away the next frame boundary lies, then how many cycles after that boundary the programmed line and offset fall. It fires there and again once per scanline until the count runs out.

The length of a scanline comes from the nominal frame length of the selected video standard. That length is divided by 263 lines for the 60 Hz standard and by 314 lines for the 50 Hz standard. The whole schedule is fixed when the request is accepted. It uses the frame position seen at that moment, so later frame-start strobes do not shift pending firings. Each firing pulses bit 10 of a status-set vector, which the surrounding interrupt controller ORs into its status register. A `busy` output lets software poll whether a burst is still outstanding. Masking and acknowledge stay in that controller.

Top module: `sched_irq_burst`

## Requirements
- R1: After reset, `irq_set_o` is all zero and `busy_o` is low.
- R2: The first firing occurs in cycle T0 + FL + y*LL + x. T0 is the last frame-start cycle at or before the request. FL is `FRAME_60` when `std_sel_i`=0 and `FRAME_50` when `std_sel_i`=1. LL is floor(FL/263) for `std_sel_i`=0 and floor(FL/314) for `std_sel_i`=1. y is `sched_line_i` and x is `sched_xoff_i`.
- R3: After each firing, the block fires again exactly LL cycles later while firings remain. For a count n≥1 it fires exactly n times, and there are no other firings.
- R4: A repeat count of 0 produces exactly one firing, the same as a count of 1.
- R5: A firing is a single-cycle pulse in which `irq_set_o` has only bit 10 (mask 0x400) set. In every other cycle `irq_set_o` is zero.
- R6: Frame-start strobes that arrive after a request has been accepted do not move any of its firings.
- R7: `busy_o` is high from the cycle after a request through the cycle of the last firing, inclusive, and low after that.
- R8: A request accepted while a burst is pending cancels the old burst. Only the new position, count and standard are then used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock; every period is one timing cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | One-cycle strobe marking the first cycle of a frame |
| std_sel_i | input | 1 | Video standard: 0 = 60 Hz (263 lines), 1 = 50 Hz (314 lines) |
| sched_req_i | input | 1 | One-cycle request to load a new burst |
| sched_line_i | input | Y_W | Target line, counted from the next frame boundary |
| sched_xoff_i | input | X_W | Extra cycle offset added after the target line |
| sched_count_i | input | N_W | Number of firings (0 treated as 1) |
| irq_set_o | output | IRQ_W | Status-set pulse vector; bit IRQ_BIT (10) pulses on each firing |
| busy_o | output | 1 | High while a burst still has firings outstanding |

## Verification
The assertions assume that a request and its fields are valid together for exactly one cycle. They also assume that the configured frame lengths give a line length of at least two cycles, so firings of one burst never touch. The bench drives requests only as single-cycle pulses, and its small frame lengths give line lengths of 2 and 3 cycles. Each request is made a few cycles after a frame strobe, well inside the frame, so the distance to the boundary is never clamped. The sweep covers both standards, first, early and last lines, several offsets and counts, strobes that arrive mid-wait, and a request that cancels another one.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int LINES_60 = 263;
    localparam int LINES_50 = 314;

    typedef enum logic [0:0] {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } vstd_e;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    // Cycles per scanline, never below one.
    function automatic int line_cycles(input int frame_len, input int lines);
        int q;
        q = frame_len / lines;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sched_frame_pos.sv
// Cycles elapsed since the latest frame-start strobe (saturating).
module sched_frame_pos #(
    parameter int POS_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    output logic [POS_W-1:0] pos_o
);
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (frame_start_i) begin
            pos_q <= POS_W'(1);
        end else if (pos_q != {POS_W{1'b1}}) begin
            pos_q <= pos_q + POS_W'(1);
        end
    end

    // The strobe cycle itself is position zero.
    assign pos_o = frame_start_i ? '0 : pos_q;
endmodule

// File: rtl/sched_delay_calc.sv
// Distance in cycles from the request cycle to the first firing.
module sched_delay_calc
    import sched_pkg::*;
#(
    parameter int FRAME_60 = 564480,
    parameter int FRAME_50 = 677376,
    parameter int Y_W      = 9,
    parameter int X_W      = 12,
    parameter int POS_W    = 21,
    parameter int D_W      = 22,
    parameter int LL_W     = 12
) (
    input  vstd_e            std_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [Y_W-1:0]   line_i,
    input  logic [X_W-1:0]   xoff_i,
    output logic [D_W-1:0]   delay_o,
    output logic [LL_W-1:0]  line_len_o
);
    localparam int LL_60 = line_cycles(FRAME_60, LINES_60);
    localparam int LL_50 = line_cycles(FRAME_50, LINES_50);

    logic [D_W-1:0] frame_len;
    logic [D_W-1:0] line_len;
    logic [D_W-1:0] pos_ext;
    logic [D_W-1:0] to_boundary;
    logic [D_W-1:0] line_span;
    logic [D_W-1:0] total;

    always_comb begin
        if (std_i == STD_50) begin
            frame_len = D_W'(FRAME_50);
            line_len  = D_W'(LL_50);
        end else begin
            frame_len = D_W'(FRAME_60);
            line_len  = D_W'(LL_60);
        end
        pos_ext     = D_W'(pos_i);
        // A late strobe leaves the boundary already passed: clamp at zero.
        to_boundary = (pos_ext >= frame_len) ? '0 : (frame_len - pos_ext);
        line_span   = D_W'(line_i) * line_len;
        total       = to_boundary + line_span + D_W'(xoff_i);
        delay_o     = (total == '0) ? D_W'(1) : total;
        line_len_o  = LL_W'(line_len);
    end
endmodule

// File: rtl/sched_burst_seq.sv
// Wait counter and repeat counter for one burst.
module sched_burst_seq
    import sched_pkg::*;
#(
    parameter int D_W  = 22,
    parameter int LL_W = 12,
    parameter int N_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic [D_W-1:0]  delay_i,
    input  logic [LL_W-1:0] line_len_i,
    input  logic [N_W-1:0]  count_i,
    output logic            fire_o,
    output logic            busy_o
);
    typedef struct packed {
        seq_state_e      state;
        logic [D_W-1:0]  wait_cnt;
        logic [N_W-1:0]  left;
        logic [LL_W-1:0] line_len;
    } seq_t;

    seq_t cur, nxt;
    logic at_target;

    assign at_target = (cur.state == SEQ_WAIT) && (cur.wait_cnt == '0);

    always_comb begin
        nxt = cur;
        if (req_i) begin
            nxt.state    = SEQ_WAIT;
            nxt.wait_cnt = delay_i - D_W'(1);
            nxt.left     = (count_i == '0) ? N_W'(1) : count_i;
            nxt.line_len = line_len_i;
        end else if (at_target) begin
            if (cur.left > N_W'(1)) begin
                nxt.left     = cur.left - N_W'(1);
                nxt.wait_cnt = D_W'(cur.line_len) - D_W'(1);
            end else begin
                nxt.state = SEQ_IDLE;
                nxt.left  = '0;
            end
        end else if (cur.state == SEQ_WAIT) begin
            nxt.wait_cnt = cur.wait_cnt - D_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.state    <= SEQ_IDLE;
            cur.wait_cnt <= '0;
            cur.left     <= '0;
            cur.line_len <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign fire_o = at_target;
    assign busy_o = (cur.state == SEQ_WAIT);
endmodule

// File: rtl/sched_irq_burst.sv
module sched_irq_burst
    import sched_pkg::*;
#(
    parameter int FRAME_60 = 564480,
    parameter int FRAME_50 = 677376,
    parameter int Y_W      = 9,
    parameter int X_W      = 12,
    parameter int N_W      = 8,
    parameter int IRQ_W    = 16,
    parameter int IRQ_BIT  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic             std_sel_i,
    input  logic             sched_req_i,
    input  logic [Y_W-1:0]   sched_line_i,
    input  logic [X_W-1:0]   sched_xoff_i,
    input  logic [N_W-1:0]   sched_count_i,
    output logic [IRQ_W-1:0] irq_set_o,
    output logic             busy_o
);
    localparam int FRAME_MAX = max_int(FRAME_60, FRAME_50);
    localparam int LL_MAX    = max_int(line_cycles(FRAME_60, LINES_60),
                                       line_cycles(FRAME_50, LINES_50));
    localparam int D_MAX     = FRAME_MAX + ((1 << Y_W) - 1) * LL_MAX + (1 << X_W);
    localparam int D_W       = $clog2(D_MAX + 1);
    localparam int POS_W     = $clog2(FRAME_MAX + 2);
    localparam int LL_W      = $clog2(LL_MAX + 1);

    logic [POS_W-1:0] frame_pos;
    logic [D_W-1:0]   first_delay;
    logic [LL_W-1:0]  line_len;
    logic             fire;

    sched_frame_pos #(.POS_W(POS_W)) u_pos (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start_i),
        .pos_o         (frame_pos)
    );

    sched_delay_calc #(
        .FRAME_60 (FRAME_60),
        .FRAME_50 (FRAME_50),
        .Y_W      (Y_W),
        .X_W      (X_W),
        .POS_W    (POS_W),
        .D_W      (D_W),
        .LL_W     (LL_W)
    ) u_calc (
        .std_i      (vstd_e'(std_sel_i)),
        .pos_i      (frame_pos),
        .line_i     (sched_line_i),
        .xoff_i     (sched_xoff_i),
        .delay_o    (first_delay),
        .line_len_o (line_len)
    );

    sched_burst_seq #(
        .D_W  (D_W),
        .LL_W (LL_W),
        .N_W  (N_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (sched_req_i),
        .delay_i    (first_delay),
        .line_len_i (line_len),
        .count_i    (sched_count_i),
        .fire_o     (fire),
        .busy_o     (busy_o)
    );

    // Status-set vector: only the designated bit can pulse.
    always_comb begin
        irq_set_o          = '0;
        irq_set_o[IRQ_BIT] = fire;
    end
endmodule

// File: rtl/sched_irq_burst_chk.sv
module sched_irq_burst_chk #(
    parameter int IRQ_W   = 16,
    parameter int IRQ_BIT = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             sched_req_i,
    input logic [IRQ_W-1:0] irq_set_o,
    input logic             busy_o
);
    // R1: first cycle after reset release shows the idle state
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && irq_set_o == '0));

    // R5: at most one status bit pulses, and only the designated one
    p_single_bit_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_set_o) && ((irq_set_o & ~(IRQ_W'(1) << IRQ_BIT)) == '0));

    // R7: a firing only happens while a burst is pending
    p_fire_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_set_o != '0) |-> busy_o);

    // R7: busy only drops right after the final firing
    p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(irq_set_o[IRQ_BIT]));

    // R8: an accepted request leaves a burst pending
    p_req_loads_r8: assert property (@(posedge clk) disable iff (rst)
        sched_req_i |=> busy_o);
endmodule

bind sched_irq_burst sched_irq_burst_chk #(
    .IRQ_W   (IRQ_W),
    .IRQ_BIT (IRQ_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sched_req_i (sched_req_i),
    .irq_set_o   (irq_set_o),
    .busy_o      (busy_o)
);

// File: tb/sched_irq_burst_bench.sv
module sched_irq_burst_bench;
    localparam int FL60 = 526;
    localparam int FL50 = 942;
    localparam int YW   = 9;
    localparam int XW   = 4;
    localparam int NW   = 4;
    localparam int IW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic          std_sel = 1'b0;
    logic          req = 1'b0;
    logic [YW-1:0] line = '0;
    logic [XW-1:0] xoff = '0;
    logic [NW-1:0] count = '0;
    logic [IW-1:0] irq_set;
    logic          busy;

    int tcyc = 0;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) tcyc = tcyc + 1;

    sched_irq_burst #(
        .FRAME_60 (FL60),
        .FRAME_50 (FL50),
        .Y_W      (YW),
        .X_W      (XW),
        .N_W      (NW),
        .IRQ_W    (IW),
        .IRQ_BIT  (10)
    ) u_sched_irq_burst (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start),
        .std_sel_i     (std_sel),
        .sched_req_i   (req),
        .sched_line_i  (line),
        .sched_xoff_i  (xoff),
        .sched_count_i (count),
        .irq_set_o     (irq_set),
        .busy_o        (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, tcyc);
        end
    endtask

    function automatic int frame_of(input bit s);
        return s ? FL50 : FL60;
    endfunction

    function automatic int line_of(input bit s);
        return s ? (FL50 / 314) : (FL60 / 263);
    endfunction

    // Strobe a frame start at the current negedge label; returns that label.
    task automatic strobe(output int t0);
        frame_start = 1'b1;
        t0 = tcyc;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (tcyc < t) @(negedge clk);
    endtask

    // Drive one request in the current cycle; returns its cycle label.
    task automatic issue(input bit s, input int y, input int x, input int c, output int sc);
        std_sel = s;
        line    = YW'(y);
        xoff    = XW'(x);
        count   = NW'(c);
        req     = 1'b1;
        sc      = tcyc;
        @(negedge clk);
        req     = 1'b0;
    endtask

    // Watch outputs from label sc+1 until after the burst should have ended.
    task automatic watch(input int sc, input int first, input int n, input int ll,
                         input int mid_at, input string tag);
        int last, fire_bad, fires, other_bad, busy_bad;
        last = first + (n - 1) * ll;
        fire_bad = 0; fires = 0; other_bad = 0; busy_bad = 0;
        while (tcyc <= last + 2 * ll + 2) begin
            bit exp_fire, exp_busy;
            exp_fire = (tcyc >= first) && (tcyc <= last) && (((tcyc - first) % ll) == 0);
            exp_busy = (tcyc > sc) && (tcyc <= last);
            if (irq_set[10]) fires++;
            if (irq_set[10] != exp_fire) fire_bad++;
            if ((irq_set & ~16'h0400) != '0) other_bad++;
            if (busy != exp_busy) busy_bad++;
            frame_start = (tcyc == mid_at);
            @(negedge clk);
        end
        frame_start = 1'b0;
        check(fire_bad == 0, {tag, " R2/R3 firing cycles"}, fire_bad, 0);
        check(fires == n, {tag, " R3 R4 firing count"}, fires, n);
        check(other_bad == 0, {tag, " R5 only bit 10"}, other_bad, 0);
        check(busy_bad == 0, {tag, " R7 busy window"}, busy_bad, 0);
        if (mid_at >= 0)
            check(fire_bad == 0, {tag, " R6 later strobe ignored"}, fire_bad, 0);
    endtask

    task automatic run_case(input bit s, input int y, input int x, input int c);
        int t0, sc, lead, first, n, mid;
        lead = (y % 4) + 1;
        strobe(t0);
        wait_until(t0 + lead);
        issue(s, y, x, c, sc);
        first = t0 + frame_of(s) + y * line_of(s) + x;
        n = (c == 0) ? 1 : c;
        mid = (c == 3) ? sc + 5 : -1;
        watch(sc, first, n, line_of(s), mid, $sformatf("std=%0d y=%0d x=%0d c=%0d", s, y, x, c));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", tcyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int ys[4];
        int xs[3];
        int cs[3];
        int t0, sa, sb;
        ys = '{0, 1, 7, 262};
        xs = '{0, 5, 15};
        cs = '{0, 1, 3};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(irq_set == '0, "R1 irq_set after reset", int'(irq_set), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        for (int s = 0; s < 2; s++)
            for (int yi = 0; yi < 4; yi++)
                for (int xi = 0; xi < 3; xi++)
                    for (int ci = 0; ci < 3; ci++)
                        run_case(s[0], ys[yi], xs[xi], cs[ci]);

        // R8: second request replaces a pending one (A would fire first)
        strobe(t0);
        wait_until(t0 + 2);
        issue(1'b0, 3, 1, 3, sa);
        wait_until(t0 + 10);
        issue(1'b1, 2, 0, 2, sb);
        watch(sb, t0 + FL50 + 2 * line_of(1'b1), 2, line_of(1'b1), -1, "R8 cancel");
        check(busy == 1'b0, "R8 idle after replacement burst", int'(busy), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule